// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Select

This block decides, for each of the two ALU operands in the execute stage of a five-stage in-order pipeline, where that operand's value should come from. The value can come from the register file read made in decode, from the result held in the execute/memory pipeline register, or from the result held in the memory/writeback pipeline register. It compares the two source register numbers of the instruction now in execute with the destination register numbers of the two older instructions still in flight. A match counts only when the older instruction really writes a register and that register is not the hard-wired zero register.

The select logic itself is combinational. The top module registers both selects once, so a decision made from the inputs in one cycle appears on the outputs after the next rising clock edge. A synchronous active-high reset clears both selects to the register-file choice. The integrating pipeline feeds the select outputs to its two operand multiplexers. The register file, the ALU and any stall logic sit outside this block.

Top module: `fwd_unit`

## Requirements
- R1: Operand A select (`fwd_a`) is decided only by the first source number `ex_rs`, and operand B select (`fwd_b`) only by the second source number `ex_rt`.
- R2: Select encoding is 2'b00 for the register-file value, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback result. The value 2'b11 never appears.
- R3: A stage is a forwarding source only while its write-enable input (`mem_wr` or `wb_wr`) is 1. A matching destination in a stage whose write enable is 0 gives 2'b00 unless the other stage forwards.
- R4: A destination number of 0 never causes forwarding, even with its write enable set and a source number of 0.
- R5: When both stages write the register an operand reads, that operand selects 2'b10, the execute/memory result.
- R6: A qualifying execute/memory match selects 2'b10 whatever the memory/writeback inputs hold.
- R7: The two operands are resolved independently, so in one cycle A and B may carry different selects, including 2'b10 and 2'b01 together.
- R8: Selects are registered. Inputs sampled at a rising edge appear on `fwd_a`/`fwd_b` after that edge. While `rst` is 1 at an edge, both outputs become 2'b00.
- R9: Over instruction sequences, an operand multiplexer driven by the selects delivers the value that the source register holds in program order. This includes three back-to-back adds to one register and a store whose base register was just written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs | input | 5 | First source register number of the instruction in execute |
| ex_rt | input | 5 | Second source register number of the instruction in execute |
| mem_rd | input | 5 | Destination register number in the execute/memory register |
| mem_wr | input | 1 | Register-write enable of the execute/memory instruction |
| wb_rd | input | 5 | Destination register number in the memory/writeback register |
| wb_wr | input | 1 | Register-write enable of the memory/writeback instruction |
| fwd_a | output | 2 | Registered source select for operand A |
| fwd_b | output | 2 | Registered source select for operand B |

## Verification
The bench targets the double hazard, where three adds chain on one register. A design that let the older writeback match win would feed the second-oldest result into the third add. Writes to register zero are also exercised. A design that skipped the zero check would forward a result the architecture discards, so an operand that reads zero would be non-zero. Matches are also driven in stages whose write enable is clear, such as a store sitting in memory or writeback, which a design ignoring the enable would forward by mistake. A store whose base comes from the previous instruction, together with mixed cases where A and B take different paths, catches swapped operand fields and selects that were wrongly coupled between the two operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    parameter int REG_W = 5;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    // Destination descriptor of an older in-flight instruction
    typedef struct packed {
        logic     wr;
        reg_idx_t rd;
    } dst_t;

    // A destination is a usable source only if it writes a non-zero register
    function automatic logic dst_live(dst_t d);
        return d.wr && (d.rd != '0);
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
(
    input  dst_t     dst,
    input  reg_idx_t src,
    output logic     hit
);

    always_comb begin
        hit = dst_live(dst) && (dst.rd == src);
    end

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic     mem_hit,
    input  logic     wb_hit,
    output fwd_sel_e sel
);

    // Younger result (execute/memory) wins; its match needs no other qualifier
    always_comb begin
        if (mem_hit)
            sel = SEL_MEM;
        else if (wb_hit)
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [REG_W-1:0]   ex_rs,
    input  logic [REG_W-1:0]   ex_rt,
    input  logic [REG_W-1:0]   mem_rd,
    input  logic               mem_wr,
    input  logic [REG_W-1:0]   wb_rd,
    input  logic               wb_wr,
    output logic [1:0]         fwd_a,
    output logic [1:0]         fwd_b
);

    localparam int NUM_OPS = 2;

    dst_t     mem_dst;
    dst_t     wb_dst;
    reg_idx_t src     [NUM_OPS];
    logic     mem_hit [NUM_OPS];
    logic     wb_hit  [NUM_OPS];
    fwd_sel_e sel_d   [NUM_OPS];
    fwd_sel_e sel_q   [NUM_OPS];

    assign mem_dst = '{wr: mem_wr, rd: mem_rd};
    assign wb_dst  = '{wr: wb_wr,  rd: wb_rd};
    assign src[0]  = ex_rs;
    assign src[1]  = ex_rt;

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        fwd_match u_mem_match (
            .dst (mem_dst),
            .src (src[op]),
            .hit (mem_hit[op])
        );
        fwd_match u_wb_match (
            .dst (wb_dst),
            .src (src[op]),
            .hit (wb_hit[op])
        );
        fwd_pick u_pick (
            .mem_hit (mem_hit[op]),
            .wb_hit  (wb_hit[op]),
            .sel     (sel_d[op])
        );

        always_ff @(posedge clk) begin
            if (rst)
                sel_q[op] <= SEL_RF;
            else
                sel_q[op] <= sel_d[op];
        end
    end

    assign fwd_a = sel_q[0];
    assign fwd_b = sel_q[1];

    // ---------------- assertions ----------------
    p_no_code3_r2: assert property (@(posedge clk) disable iff (rst)
        (fwd_a != 2'b11) && (fwd_b != 2'b11));

    p_idle_stages_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_wr && !wb_wr) |=> (fwd_a == 2'b00) && (fwd_b == 2'b00));

    p_zero_dest_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd == '0 && wb_rd == '0) |=> (fwd_a == 2'b00) && (fwd_b == 2'b00));

    p_mem_wins_a_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_rd != '0 && mem_rd == ex_rs) |=> (fwd_a == 2'b10));

    p_mem_wins_b_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_rd != '0 && mem_rd == ex_rt) |=> (fwd_b == 2'b10));

    p_wb_path_a_r1: assert property (@(posedge clk) disable iff (rst)
        (wb_wr && wb_rd != '0 && wb_rd == ex_rs &&
         !(mem_wr && mem_rd == ex_rs)) |=> (fwd_a == 2'b01));

endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;

    localparam int RW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] ex_rs = '0, ex_rt = '0, mem_rd = '0, wb_rd = '0;
    logic          mem_wr = 1'b0, wb_wr = 1'b0;
    logic [1:0]    fwd_a, fwd_b;

    always #4 clk = ~clk;   // 125 MHz

    fwd_unit dut (
        .clk(clk), .rst(rst),
        .ex_rs(ex_rs), .ex_rt(ex_rt),
        .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_rd(wb_rd), .wb_wr(wb_wr),
        .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [RW-1:0] rd;
        logic [RW-1:0] rs;
        logic [RW-1:0] rt;
        logic          wr;
        logic [DW-1:0] res;
    } instr_t;

    typedef struct {
        logic [1:0]    ea;
        logic [1:0]    eb;
        logic          chk_val;
        logic [RW-1:0] rs;
        logic [RW-1:0] rt;
        logic [DW-1:0] va;
        logic [DW-1:0] vb;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] gold [32];   // program-order register values
    logic [DW-1:0] prf  [32];   // register file written at writeback retirement
    instr_t        p_ex, p_mem, p_wb;
    instr_t        nop_i;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected select from the requirements (R2..R6)
    function automatic logic [1:0] exp_sel(input logic [RW-1:0] s,
                                           input logic mw, input logic [RW-1:0] mr,
                                           input logic ww, input logic [RW-1:0] wr_);
        if (mw && mr != 0 && mr == s) return 2'b10;
        if (ww && wr_ != 0 && wr_ == s) return 2'b01;
        return 2'b00;
    endfunction

    // Raw driver: explicit stage contents, selects only
    task automatic drive_raw(input logic [RW-1:0] rs, input logic [RW-1:0] rt,
                             input logic mw, input logic [RW-1:0] mr,
                             input logic ww, input logic [RW-1:0] wr_,
                             input logic [1:0] ea, input logic [1:0] eb, input string tag);
        exp_t e;
        @(negedge clk);
        ex_rs = rs; ex_rt = rt; mem_wr = mw; mem_rd = mr; wb_wr = ww; wb_rd = wr_;
        e = '{ea: ea, eb: eb, chk_val: 1'b0, rs: rs, rt: rt, va: '0, vb: '0, tag: tag};
        sb.push_back(e);
        @(posedge clk);
    endtask

    // Instruction driver: advances the modelled pipeline by one slot
    task automatic issue(input logic [RW-1:0] rd, input logic [RW-1:0] rs,
                         input logic [RW-1:0] rt, input logic wr, input string tag);
        exp_t   e;
        instr_t ni;
        @(negedge clk);
        if (p_wb.wr && p_wb.rd != 0) prf[p_wb.rd] = p_wb.res;
        p_wb  = p_mem;
        p_mem = p_ex;
        ni.rd = rd; ni.rs = rs; ni.rt = rt; ni.wr = wr;
        ni.res = gold[rs] + gold[rt];
        e.va = gold[rs]; e.vb = gold[rt];
        if (wr && rd != 0) gold[rd] = ni.res;
        p_ex = ni;
        ex_rs = rs; ex_rt = rt;
        mem_wr = p_mem.wr; mem_rd = p_mem.rd;
        wb_wr = p_wb.wr;   wb_rd = p_wb.rd;
        e.ea = exp_sel(rs, p_mem.wr, p_mem.rd, p_wb.wr, p_wb.rd);
        e.eb = exp_sel(rt, p_mem.wr, p_mem.rd, p_wb.wr, p_wb.rd);
        e.chk_val = 1'b1; e.rs = rs; e.rt = rt; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
    endtask

    function automatic logic [DW-1:0] mux_val(input logic [1:0] s, input logic [RW-1:0] r);
        case (s)
            2'b10:   return p_mem.res;
            2'b01:   return p_wb.res;
            default: return prf[r];
        endcase
    endfunction

    // Monitor: pops one expectation per cycle after the capturing edge (R8)
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " sel A"}, {30'd0, fwd_a}, {30'd0, e.ea});
                check({e.tag, " sel B"}, {30'd0, fwd_b}, {30'd0, e.eb});
                if (e.chk_val) begin
                    check({e.tag, " value A R9"}, mux_val(fwd_a, e.rs), e.va);
                    check({e.tag, " value B R9"}, mux_val(fwd_b, e.rt), e.vb);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        nop_i = '{rd: '0, rs: '0, rt: '0, wr: 1'b0, res: '0};
        p_ex = nop_i; p_mem = nop_i; p_wb = nop_i;
        for (int i = 0; i < 32; i++) begin
            gold[i] = (i == 0) ? '0 : 32'h100 * i + 32'h11;
            prf[i]  = gold[i];
        end

        // R8: reset clears selects even with live matches at the inputs
        ex_rs = 5'd3; ex_rt = 5'd4; mem_wr = 1'b1; mem_rd = 5'd3; wb_wr = 1'b1; wb_rd = 5'd4;
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset fwd_a", {30'd0, fwd_a}, 32'd0);
        check("R8 reset fwd_b", {30'd0, fwd_b}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Directed select cases
        drive_raw(5'd3, 5'd9, 1'b1, 5'd3, 1'b0, 5'd0, 2'b10, 2'b00, "R1 rs-only mem match");
        drive_raw(5'd9, 5'd3, 1'b1, 5'd3, 1'b0, 5'd0, 2'b00, 2'b10, "R1 rt-only mem match");
        drive_raw(5'd6, 5'd7, 1'b0, 5'd6, 1'b0, 5'd7, 2'b00, 2'b00, "R3 write enables off");
        drive_raw(5'd6, 5'd7, 1'b0, 5'd6, 1'b1, 5'd6, 2'b01, 2'b00, "R3 mem off wb on");
        drive_raw(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 2'b00, 2'b00, "R4 zero register");
        drive_raw(5'd8, 5'd8, 1'b1, 5'd8, 1'b1, 5'd8, 2'b10, 2'b10, "R5 double hazard");
        drive_raw(5'd8, 5'd2, 1'b1, 5'd8, 1'b0, 5'd8, 2'b10, 2'b00, "R6 mem with wb disabled");
        drive_raw(5'd8, 5'd2, 1'b1, 5'd8, 1'b1, 5'd0, 2'b10, 2'b00, "R6 mem with wb zero dest");
        drive_raw(5'd10, 5'd11, 1'b1, 5'd10, 1'b1, 5'd11, 2'b10, 2'b01, "R7 A mem B wb");
        drive_raw(5'd11, 5'd10, 1'b1, 5'd10, 1'b1, 5'd11, 2'b01, 2'b10, "R7 A wb B mem");
        drive_raw(5'd12, 5'd12, 1'b0, 5'd12, 1'b1, 5'd0, 2'b00, 2'b00, "R2 R3 no source");

        // R9 sequences through the modelled pipeline
        issue(5'd1, 5'd1, 5'd2, 1'b1, "R5 R9 chain add1");
        issue(5'd1, 5'd1, 5'd3, 1'b1, "R5 R9 chain add2");
        issue(5'd1, 5'd1, 5'd4, 1'b1, "R5 R9 chain add3");
        issue(5'd0, 5'd1, 5'd5, 1'b0, "R9 store base dep");
        issue(5'd7, 5'd8, 5'd9, 1'b1, "R9 indep 1");
        issue(5'd10, 5'd11, 5'd12, 1'b1, "R9 indep 2");
        issue(5'd13, 5'd7, 5'd10, 1'b1, "R7 R9 A wb B mem");
        issue(5'd0, 5'd2, 5'd3, 1'b1, "R4 R9 write zero");
        issue(5'd4, 5'd0, 5'd0, 1'b1, "R4 R9 read zero");
        issue(5'd0, 5'd13, 5'd4, 1'b0, "R3 R9 store src");
        issue(5'd5, 5'd13, 5'd4, 1'b1, "R3 R9 past store");
        issue(5'd6, 5'd5, 5'd5, 1'b1, "R9 both from mem");
        for (int k = 0; k < 3; k++) issue(5'd0, 5'd0, 5'd0, 1'b0, "R9 drain");

        @(posedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule